// File: doc/BRIEF.md
# Interrupt Request Aggregator

The block gathers interrupt events from sixteen user-logic lines, a receive packet engine, a transmit packet engine and an output-FIFO level detector. It turns each event into a sticky pending bit and presents one request line to a serial-bus endpoint. The endpoint answers that line with a grant. Each source is edge-captured, so a source that stays high raises its pending bit once and then cannot raise it again until it goes low.

Host software reaches the block through a small word-wide register port that the host-side packet decoder drives. Software reads the raw pending word, programs a block mask, sets pending bits for test, and clears serviced bits with write-one-to-clear. A three-state sequencer raises the request, holds it until the grant, and then waits until no unmasked pending bit remains before it can raise another request.

Top module: `irq_aggregator`

## Requirements
- R1: On the first clock edge at which a source is seen high after being low, its pending bit sets. A source held high does not set the bit again. The user lines map to bits 15:0, the receive engine to bit 16, the transmit engine to bit 17 and the FIFO level event to bit 18.
- R2: A pending bit stays set until a write to the clear register (address 3) carries a one in that bit position.
- R3: A write to the set register (address 2) sets every pending bit that has a one in the write data. Ones in bits 31:19 are dropped.
- R4: If a source edge and a clear of the same bit fall in the same cycle, the edge wins and the bit stays set.
- R5: The mask register (address 1) reads back as written over bits 18:0. A one in a mask bit stops that pending bit from causing a request.
- R6: From idle, the request output goes high one cycle after any pending bit with a zero mask bit exists. It stays high until the grant is sampled high, and it is low in the next cycle.
- R7: After a grant, the request stays low until every unmasked pending bit has been cleared. The block then needs one idle cycle before a new request can start.
- R8: Reads return data one cycle after the read strobe. Address 0 returns the raw pending bits whatever the mask holds. Addresses 2 and 3 read as zero, bits 31:19 always read as zero, and writes to address 0 have no effect.
- R9: After reset the pending and mask registers are zero and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usr_irq | input | 16 | User-logic interrupt lines |
| rx_irq | input | 1 | Receive engine event |
| tx_irq | input | 1 | Transmit engine event |
| fifo_irq | input | 1 | Output-FIFO level event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 32 | Read data, one cycle after the strobe |
| irq_req | output | 1 | Interrupt request to the endpoint |
| irq_gnt | input | 1 | Grant from the endpoint |

## Verification
The bench builds the block with its default parameters: sixteen user lines, 32-bit registers and 2-bit addresses. This leaves thirteen reserved bits at the top of every word, so random set and mask writes keep running into bits that must be dropped. With only nineteen live sources, random clear writes often empty the pending word. That drives the sequencer back through its waiting state to idle many times, with grants arriving early, late and in the same cycle as new edges.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_REQUEST    = 2'd1,
    ST_WAIT_CLEAR = 2'd2
  } req_state_t;

  localparam int OFS_PEND = 0;
  localparam int OFS_MASK = 1;
  localparam int OFS_SET  = 2;
  localparam int OFS_CLR  = 3;

  localparam int EXTRA_SRCS = 3;

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int SRC_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] rise_o
);

  logic [SRC_W-1:0] src_q;

  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  for (genvar g = 0; g < SRC_W; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= 1'b0;
      else        src_q[g] <= src_i[g];
    end
    assign rise_o[g] = edge_up(src_i[g], src_q[g]);
  end

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file #(
  parameter int SRC_W  = 19,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  rise_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] clr_vec_o
);
  import irq_agg_pkg::*;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t LIVE_BITS = word_t'({SRC_W{1'b1}});
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  word_t pend_q, mask_q, set_vec, clr_vec, rise_w, pend_n;

  // clear first, then software set, then hardware edges: edges win
  function automatic word_t merge_pend(input word_t cur, input word_t clr,
                                       input word_t set, input word_t hw);
    return ((cur & ~clr) | set | hw) & LIVE_BITS;
  endfunction

  function automatic word_t read_mux(input logic [ADDR_W-1:0] a,
                                     input word_t p, input word_t m);
    word_t r;
    r = '0;
    if (a == A_PEND) r = p;
    else if (a == A_MASK) r = m;
    return r;
  endfunction

  assign rise_w  = word_t'(rise_i);
  assign set_vec = (wr_en && wr_addr == A_SET) ? (wr_data & LIVE_BITS) : '0;
  assign clr_vec = (wr_en && wr_addr == A_CLR) ? (wr_data & LIVE_BITS) : '0;
  assign pend_n  = merge_pend(pend_q, clr_vec, set_vec, rise_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      rd_data <= '0;
    end else begin
      pend_q <= pend_n;
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data & LIVE_BITS;
      if (rd_en) rd_data <= read_mux(rd_addr, pend_q, mask_q);
    end
  end

  assign pend_o    = pend_q;
  assign mask_o    = mask_q;
  assign clr_vec_o = clr_vec;

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active_i,
  input  logic                    gnt_i,
  output logic                    req_o,
  output irq_agg_pkg::req_state_t state_o
);
  import irq_agg_pkg::*;

  req_state_t state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:       if (active_i) state_n = ST_REQUEST;
      ST_REQUEST:    if (gnt_i) state_n = ST_WAIT_CLEAR;
      ST_WAIT_CLEAR: if (!active_i) state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign req_o   = (state_q == ST_REQUEST);
  assign state_o = state_q;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int USR_LINES = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [USR_LINES-1:0] usr_irq,
  input  logic                 rx_irq,
  input  logic                 tx_irq,
  input  logic                 fifo_irq,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_wr_addr,
  input  logic [DATA_W-1:0]    reg_wr_data,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_rd_addr,
  output logic [DATA_W-1:0]    reg_rd_data,
  output logic                 irq_req,
  input  logic                 irq_gnt
);
  import irq_agg_pkg::*;

  localparam int SRC_W = USR_LINES + EXTRA_SRCS;

  logic [SRC_W-1:0]  src_w, rise_w;
  logic [DATA_W-1:0] pend_w, mask_w, clr_vec_w;
  logic              active_w, fsm_idle_w;
  req_state_t        state_w;

  // bit order is fixed: user lines low, then receive, transmit, FIFO level
  assign src_w = {fifo_irq, tx_irq, rx_irq, usr_irq};

  irq_src_capture #(.SRC_W(SRC_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_w), .rise_o(rise_w)
  );

  irq_reg_file #(.SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .pend_o(pend_w), .mask_o(mask_w), .clr_vec_o(clr_vec_w)
  );

  assign active_w = |(pend_w & ~mask_w);

  irq_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .active_i(active_w), .gnt_i(irq_gnt),
    .req_o(irq_req), .state_o(state_w)
  );

  assign fsm_idle_w = (state_w == ST_IDLE);

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int SRC_W  = 19,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic              irq_gnt,
  input logic [SRC_W-1:0]  rise,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] clr_vec,
  input logic [DATA_W-1:0] rd_data,
  input logic              active,
  input logic              fsm_idle
);
  typedef logic [DATA_W-1:0] word_t;

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & word_t'($past(rise))) == word_t'($past(rise)))); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((pend & $past(pend)) == $past(pend))); // R2

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(word_t'(rise) & clr_vec)) |=>
      ((pend & $past(word_t'(rise) & clr_vec)) == $past(word_t'(rise) & clr_vec))); // R4

  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && !active) |=> !irq_req); // R5

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_gnt) |=> irq_req); // R6

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_gnt) |=> !irq_req); // R6

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> SRC_W) == '0); // R8

endmodule

bind irq_aggregator irq_aggregator_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_gnt(irq_gnt),
  .rise(rise_w), .pend(pend_w), .clr_vec(clr_vec_w), .rd_data(reg_rd_data),
  .active(active_w), .fsm_idle(fsm_idle_w)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int USR = 16;
  localparam int DW  = 32;
  localparam int AW  = 2;
  localparam int SW  = USR + 3;
  localparam int MAX_CYCLES = 20000;
  localparam logic [DW-1:0] LIVE = {{(DW-SW){1'b0}}, {SW{1'b1}}};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n;
  logic [USR-1:0] usr_irq;
  logic rx_irq, tx_irq, fifo_irq;
  logic reg_wr_en, reg_rd_en, irq_gnt;
  logic [AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [DW-1:0] reg_wr_data, reg_rd_data;
  logic irq_req;

  irq_aggregator #(.USR_LINES(USR), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .usr_irq(usr_irq), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .fifo_irq(fifo_irq), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .irq_req(irq_req), .irq_gnt(irq_gnt)
  );

  // reference model (0 idle, 1 requesting, 2 waiting for clear)
  logic [DW-1:0] m_pend, m_mask;
  logic [SW-1:0] m_prev;
  int m_state;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (a == 2'd0) return m_pend;
    if (a == 2'd1) return m_mask;
    return '0;
  endfunction

  function automatic logic [DW-1:0] model_pend_next(input logic [DW-1:0] p,
      input logic [SW-1:0] edges);
    logic [DW-1:0] r = p;
    if (reg_wr_en && reg_wr_addr == 2'd3) r = r & ~reg_wr_data;
    if (reg_wr_en && reg_wr_addr == 2'd2) r = r | (reg_wr_data & LIVE);
    return r | DW'(edges);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    usr_irq = '0; rx_irq = 0; tx_irq = 0; fifo_irq = 0;
    reg_wr_en = 0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_en = 0; reg_rd_addr = '0; irq_gnt = 0;
  endtask

  task automatic step(input string tag);
    logic [SW-1:0] src, edges;
    logic act, rd_issued;
    logic [DW-1:0] rd_exp;
    src = {fifo_irq, tx_irq, rx_irq, usr_irq};
    edges = src & ~m_prev;
    act = |(m_pend & ~m_mask);
    rd_issued = reg_rd_en;
    rd_exp = model_read(reg_rd_addr);
    @(posedge clk);
    m_prev = src;
    m_pend = model_pend_next(m_pend, edges);
    if (reg_wr_en && reg_wr_addr == 2'd1) m_mask = reg_wr_data & LIVE;
    case (m_state)
      0: if (act) m_state = 1;
      1: if (irq_gnt) m_state = 2;
      default: if (!act) m_state = 0;
    endcase
    @(negedge clk);
    check(tag, DW'(irq_req), DW'(m_state == 1));
    if (rd_issued) check(tag, reg_rd_data, rd_exp);
    idle_inputs();
    usr_irq = src[USR-1:0]; rx_irq = src[USR]; tx_irq = src[USR+1]; fifo_irq = src[USR+2];
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    reg_rd_en = 1; reg_rd_addr = a; step(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d; step(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst_n = 0;
    m_pend = '0; m_mask = '0; m_prev = '0; m_state = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R9", DW'(irq_req), '0);
    rd(2'd0, "R9");
    rd(2'd1, "R9");

    // R1: single pulse on user line 3
    usr_irq[3] = 1; step("R1");
    usr_irq[3] = 0; step("R6");
    rd(2'd0, "R1");
    check("R1", reg_rd_data, 32'h0000_0008);
    irq_gnt = 1; step("R6");
    step("R7");
    // R2: bit persists
    repeat (3) step("R2");
    rd(2'd0, "R2");
    // R1: held receive line, cleared while still high, no retrigger
    rx_irq = 1; repeat (3) step("R1");
    wr(2'd3, 32'h0001_0008, "R7");
    repeat (2) step("R7");
    rd(2'd0, "R1");
    check("R1", reg_rd_data, 32'h0);
    rx_irq = 0; step("R1");
    // R6: request held without grant
    fifo_irq = 1; step("R6");
    repeat (4) step("R6");
    irq_gnt = 1; step("R6");
    fifo_irq = 0; step("R7");
    // R3: set register with reserved ones
    wr(2'd2, 32'hFFFF_FFFF, "R3");
    rd(2'd0, "R3");
    check("R3", reg_rd_data, 32'h0007_FFFF);
    wr(2'd3, 32'hFFFF_FFFF, "R2");
    step("R7");
    // R4: transmit edge beats a clear of the same bit
    tx_irq = 1; reg_wr_en = 1; reg_wr_addr = 2'd3; reg_wr_data = 32'h0002_0000; step("R4");
    rd(2'd0, "R4");
    check("R4", reg_rd_data, 32'h0002_0000);
    tx_irq = 0; irq_gnt = 1; step("R6");
    wr(2'd3, 32'h0002_0000, "R7");
    // R5: mask blocks requests, pending still visible raw (R8)
    wr(2'd1, 32'hFFFF_FFFF, "R5");
    rd(2'd1, "R5");
    check("R5", reg_rd_data, 32'h0007_FFFF);
    usr_irq[15] = 1; step("R5");
    usr_irq[15] = 0; repeat (3) step("R5");
    rd(2'd0, "R8");
    check("R8", reg_rd_data, 32'h0000_8000);
    wr(2'd0, 32'h0, "R8");
    rd(2'd0, "R8");
    rd(2'd2, "R8");
    rd(2'd3, "R8");
    wr(2'd1, 32'h0, "R5");
    repeat (2) step("R6");
    irq_gnt = 1; step("R6");
    wr(2'd2, 32'h0000_0001, "R7");
    repeat (2) step("R7");
    wr(2'd3, 32'h0000_8001, "R7");
    step("R7");
    step("R7");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < USR; b++)
        if ($urandom_range(0, 7) == 0) usr_irq[b] = ~usr_irq[b];
      if ($urandom_range(0, 5) == 0) rx_irq = ~rx_irq;
      if ($urandom_range(0, 5) == 0) tx_irq = ~tx_irq;
      if ($urandom_range(0, 5) == 0) fifo_irq = ~fifo_irq;
      irq_gnt = ($urandom_range(0, 2) == 0);
      reg_wr_en = ($urandom_range(0, 3) == 0);
      reg_wr_addr = AW'($urandom_range(0, 3));
      reg_wr_data = ($urandom_range(0, 1) == 0) ? $urandom() : 32'hFFFF_FFFF;
      if (reg_wr_addr == 2'd1) reg_wr_data = reg_wr_data & $urandom();
      reg_rd_en = ($urandom_range(0, 1) == 0);
      reg_rd_addr = AW'($urandom_range(0, 3));
      step("R6");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule